// File: doc/BRIEF.md
# Configurable External Interrupt Input Controller

This block turns a small group of asynchronous interrupt pins into clean, per-channel interrupt requests. Software sets up each channel separately. It chooses whether the channel reacts to a level or to an edge, and whether the active sense is high/rising or low/falling. Every pin first passes through a two-flop synchronizer. The synchronized value then goes either straight to the request line (level mode) or into a sticky flag that an active edge sets (edge mode).

A single register port serves all channels. Each channel has one small control word, selected by channel number. A write loads the sense and polarity bits. In the same write, a one in the clear bit drops a captured edge. A read returns the configuration and the live status of the selected channel. The request line of each channel is always equal to the status that a read of that channel would show. Prioritization and vectoring belong to the interrupt controller that consumes these lines.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every channel reads back all zeros (level mode, active high). With all pins low, every request line is 0.
- R2: A pin change reaches a level-mode request line exactly two clock edges after the pin settles, and not after only one edge.
- R3: In level mode with control bit 1 = 0, the request line is 1 while the synchronized pin is high and 0 while it is low.
- R4: In level mode with control bit 1 = 1, the request line is 1 while the synchronized pin is low and 0 while it is high.
- R5: In edge mode (control bit 0 = 1) with bit 1 = 0, a rising edge sets the request line. The line stays set after the pin returns low.
- R6: In edge mode with bit 1 = 1, a falling edge sets the request line.
- R7: In edge mode, a write to the channel with control bit 2 = 1 clears a captured event. The request line is 0 after that write's clock edge.
- R8: If an active edge is detected in the same cycle as a clear write, the event is kept and the request line stays 1.
- R9: In level mode, writing 1 to control bit 2 has no effect on the request line.
- R10: A read of channel n returns the sense in bit 0 and the polarity in bit 1. Bit 2 reads 0. Bit 3 equals request line n, and all higher bits read 0.
- R11: A write to one channel leaves the configuration and request line of every other channel unchanged.
- R12: In edge mode, the edge opposite to the selected polarity does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | NCH | Raw asynchronous interrupt pins |
| wr_en | input | 1 | Write strobe for the control word of the channel in wr_sel |
| wr_sel | input | IDX_W | Channel written |
| wr_data | input | DATA_W | Write data: bit0 sense, bit1 polarity, bit2 clear |
| rd_sel | input | IDX_W | Channel read |
| rd_data | output | DATA_W | Combinational read of the control word and status |
| irq_req | output | NCH | Interrupt request, one per channel |

## Verification
The assertions assume that a clear always arrives as part of a full control-word write. The written sense bit therefore decides whether a flag may survive that edge. They also assume that rd_sel names an existing channel whenever the read data is compared against a request line. The bench changes pins only on falling clock edges and holds each level for at least three clocks. This keeps every edge separable after synchronization. For the coincident-edge test, the bench places the clear write in the single cycle in which the edge is seen after synchronization.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int CTL_SENSE_BIT = 0;
  localparam int CTL_POL_BIT   = 1;
  localparam int CTL_CLR_BIT   = 2;
  localparam int CTL_STAT_BIT  = 3;
  localparam int CTL_USED_W    = 4;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  typedef struct packed {
    logic   pol;
    sense_e sense;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RESET = '{pol: 1'b0, sense: SENSE_LEVEL};

  // active edge relative to polarity: pol=0 rising, pol=1 falling
  function automatic logic active_edge(input logic cur, input logic prev, input logic pol);
    return pol ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // level after polarity correction
  function automatic logic level_active(input logic cur, input logic pol);
    return cur ^ pol;
  endfunction

  // sticky flag update; an event beats a clear, leaving edge mode empties it
  function automatic logic next_flag(input logic edge_mode, input logic evt,
                                     input logic flag, input logic clr);
    return edge_mode & (evt | (flag & ~clr));
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
  import eirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  logic      wr_hit,
  input  chan_cfg_t wr_cfg,
  input  logic      wr_clr,
  output chan_cfg_t cfg_q,
  output logic      status
);

  logic      prev_q;
  logic      flag_q;
  logic      evt;
  logic      clr_req;
  logic      lvl_act;
  logic      edge_now;
  logic      edge_next;
  chan_cfg_t cfg_d;

  assign cfg_d     = wr_hit ? wr_cfg : cfg_q;
  assign clr_req   = wr_hit & wr_clr;
  assign evt       = active_edge(pin_s, prev_q, cfg_q.pol);
  assign lvl_act   = level_active(pin_s, cfg_q.pol);
  assign edge_now  = (cfg_q.sense == SENSE_EDGE);
  assign edge_next = (cfg_d.sense == SENSE_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      cfg_q  <= CFG_RESET;
    end else begin
      prev_q <= pin_s;
      flag_q <= next_flag(edge_next, evt, flag_q, clr_req);
      cfg_q  <= cfg_d;
    end
  end

  assign status = edge_now ? flag_q : lvl_act;

  // edge seen while staying in edge mode raises the request next cycle
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && evt && !(wr_hit && wr_cfg.sense == SENSE_LEVEL)) |=> status);

  // a captured event holds without a clear
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && status && !wr_hit) |=> status);

  // clear with no coincident edge empties the flag
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt) |=> !flag_q);

  // coincident edge beats the clear
  assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && clr_req && evt && wr_cfg.sense == SENSE_EDGE) |=> status);

  // level mode keeps no latched state
  assert_level_no_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_now && !wr_hit) |=> !flag_q);

endmodule

// File: rtl/eirq_rdmux.sv
module eirq_rdmux
  import eirq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [IDX_W-1:0]  sel,
  input  chan_cfg_t         cfg   [NCH],
  input  logic [NCH-1:0]    stat,
  output logic [DATA_W-1:0] data
);

  always_comb begin
    data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(sel) == i) begin
        data[CTL_SENSE_BIT] = cfg[i].sense;
        data[CTL_POL_BIT]   = cfg[i].pol;
        data[CTL_STAT_BIT]  = stat[i];
      end
    end
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter  int NCH         = 4,
  parameter  int DATA_W      = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int IDX_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ext_pin,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    irq_req
);

  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] chan_stat;
  logic [NCH-1:0] wr_hit;
  chan_cfg_t      chan_cfg [NCH];
  chan_cfg_t      wr_cfg;
  logic           wr_clr;
  wire            unused_wr_bits = ^wr_data;

  assign wr_cfg.sense = sense_e'(wr_data[CTL_SENSE_BIT]);
  assign wr_cfg.pol   = wr_data[CTL_POL_BIT];
  assign wr_clr       = wr_data[CTL_CLR_BIT];

  eirq_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ext_pin),
    .q_sync  (pin_s)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign wr_hit[c] = wr_en && (int'(wr_sel) == c);

      eirq_chan u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_s  (pin_s[c]),
        .wr_hit (wr_hit[c]),
        .wr_cfg (wr_cfg),
        .wr_clr (wr_clr),
        .cfg_q  (chan_cfg[c]),
        .status (chan_stat[c])
      );

      // untouched channels keep their configuration
      assert_other_chan_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit[c]) |=> (chan_cfg[c] == $past(chan_cfg[c])));
    end
  endgenerate

  assign irq_req = chan_stat;

  eirq_rdmux #(.NCH(NCH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdmux (
    .sel  (rd_sel),
    .cfg  (chan_cfg),
    .stat (chan_stat),
    .data (rd_data)
  );

  // status bit read back matches the request line, clear bit always reads 0
  assert_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_sel) < NCH) |->
      (rd_data[CTL_STAT_BIT] == irq_req[rd_sel] && rd_data[CTL_CLR_BIT] == 1'b0));

endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;

  localparam int NCH    = 4;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    ext_pin = '0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [IDX_W-1:0]  rd_sel = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NCH-1:0]    irq_req;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl #(.NCH(NCH), .DATA_W(DATA_W)) u_ext_irq_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_pin (ext_pin),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .irq_req (irq_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input int ch, input logic [DATA_W-1:0] d);
    wr_sel  = IDX_W'(ch);
    wr_data = d;
    wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic rd(input int ch, output logic [DATA_W-1:0] d);
    rd_sel = IDX_W'(ch);
    #0.5;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);
      check($sformatf("R1 reset readback ch%0d", c), d, 0);
    end
    check("R1 reset irq", irq_req, 0);
  endtask

  task automatic t_level_high;
    ext_pin[2] = 1'b1;
    tick(1);
    check("R2 one edge not yet", irq_req[2], 0);
    tick(1);
    check("R2 two edges visible", irq_req[2], 1);
    check("R3 level high asserted", irq_req[2], 1);
    ext_pin[2] = 1'b0;
    tick(2);
    check("R3 level high released", irq_req[2], 0);
  endtask

  task automatic t_level_low;
    wr(3, 8'h02);
    check("R4 active low with pin low", irq_req[3], 1);
    ext_pin[3] = 1'b1;
    tick(2);
    check("R4 active low with pin high", irq_req[3], 0);
    ext_pin[3] = 1'b0;
    tick(2);
    check("R4 active low re-asserted", irq_req[3], 1);
  endtask

  task automatic t_edge_rise;
    wr(0, 8'h01);
    tick(2);
    check("R5 no event yet", irq_req[0], 0);
    ext_pin[0] = 1'b1;
    tick(3);
    check("R5 rising edge captured", irq_req[0], 1);
    ext_pin[0] = 1'b0;
    tick(3);
    check("R5 sticky after pin low", irq_req[0], 1);
  endtask

  task automatic t_edge_vs_clear;
    logic [DATA_W-1:0] d;
    ext_pin[0] = 1'b1;
    tick(2);
    wr(0, 8'h05);
    check("R8 edge with clear keeps flag", irq_req[0], 1);
    rd(0, d);
    check("R10 clear bit reads 0 status 1", d, 8'h09);
    wr(0, 8'h05);
    check("R7 clear drops flag", irq_req[0], 0);
    ext_pin[0] = 1'b0;
    tick(3);
    check("R12 falling edge ignored in rising mode", irq_req[0], 0);
  endtask

  task automatic t_edge_fall;
    logic [DATA_W-1:0] d;
    wr(1, 8'h03);
    ext_pin[1] = 1'b1;
    tick(3);
    check("R12 rising edge ignored in falling mode", irq_req[1], 0);
    ext_pin[1] = 1'b0;
    tick(3);
    check("R6 falling edge captured", irq_req[1], 1);
    rd(1, d);
    check("R10 readback ch1", d, 8'h0B);
  endtask

  task automatic t_level_clear;
    logic [DATA_W-1:0] d;
    ext_pin[2] = 1'b1;
    tick(3);
    wr(2, 8'h04);
    check("R9 clear in level mode no effect", irq_req[2], 1);
    tick(1);
    check("R9 still asserted", irq_req[2], 1);
    rd(1, d);
    check("R11 ch1 untouched by ch2 write", d, 8'h0B);
    check("R11 ch1 request kept", irq_req[1], 1);
    rd(3, d);
    check("R11 ch3 config kept", d, 8'h0A);
    ext_pin[2] = 1'b0;
    tick(2);
    check("R3 level released after clear test", irq_req[2], 0);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_level_high();
    t_level_low();
    t_edge_rise();
    t_edge_vs_clear();
    t_edge_fall();
    t_level_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule